// File: doc/BRIEF.md
# Receive Sample Descriptor Ring Writer

This block takes a stream of complex baseband samples, one 32-bit word per valid cycle, and packs them into fixed-size descriptors. It writes the descriptors into a circular buffer through a simple word-addressed memory write port. Each descriptor occupies 32 words, which is 128 bytes. Words 4 to 31 carry 28 samples. Word 0 is a header, written only after the descriptor's last sample has gone out, and it carries a valid flag and a running sequence number.

A consumer polls the published write index and processes every slot behind it. It reports its own progress back on a read index. The writer never fills the slot that would make the two indices equal. When the ring is full it discards incoming samples and raises an overflow flag, and it resumes on a descriptor boundary once the consumer moves on.

The memory port carries one write per cycle. A header therefore costs one port cycle, and that cycle is absorbed by a short write queue between sample acceptance and the memory port.

Top module: `rx_desc_ring_writer`

## Requirements
- R1: An accepted sample word is stored unchanged, with I in bits 15:0 and Q in bits 31:16. The n-th accepted sample of a descriptor (n = 0..27) goes to word address slot*32 + 4 + n. Accepted samples fill descriptors in arrival order.
- R2: Every descriptor holds exactly 28 samples. Its header word is written only after all 28 of its sample words have been written.
- R3: The header word sits at offset 0 of its slot. Bit 31 is 1 (valid), bits 30:16 are 0, and bits 15:0 hold a sequence number that is 0 for the first descriptor after reset and rises by one per descriptor. Offsets 1 to 3 are never written.
- R4: `wrIndex` is 0 after reset. It advances by one, wrapping from NUM_DESC-1 to 0, in the same cycle that a header write appears on the memory port, and it changes at no other time.
- R5: Slots are filled in the order 0, 1, …, NUM_DESC-1, 0, and so on. Every sample write targets the slot equal to the current `wrIndex`.
- R6: A sample that would begin a new descriptor in slot s is dropped when (s+1) mod NUM_DESC equals `rdIndex`, so at most NUM_DESC-1 completed descriptors wait unread. `overflow` is high in the cycle after a dropped sample, low in the cycle after an accepted sample, and unchanged after cycles without `sampleValid`.
- R7: Once `rdIndex` moves, the next sample is written at offset 4 of the slot that was blocked. Samples dropped while the ring was full leave no trace in memory or in the sequence numbers.
- R8: The write queue holds two entries, and a header write takes the port for one cycle. Consider a stream with a sample on every cycle, starting at a descriptor boundary with an empty queue. In that stream only the third sample after the descriptor's 28th is dropped, with `overflow` raised, and every other sample is accepted.
- R9: During and straight after reset, `memWrEn` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A sample is present this cycle |
| sampleData | input | 32 | Sample word: I in 15:0, Q in 31:16 |
| rdIndex | input | IDX_W | Next slot the consumer will read |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Word address: slot in the upper bits, word offset in the lower 5 |
| memWrData | output | 32 | Word to write |
| wrIndex | output | IDX_W | Slot after the last completed descriptor |
| overflow | output | 1 | The previous sample was dropped |

## Verification
Each kind of internal error shows up at the ports in its own way:
- A wrong sample counter or fill slot appears as misplaced or missing words in the descriptor that the next header closes, so it is caught no more than 28 accepted samples later.
- A wrong sequence counter or slot pointer shows in that same header, and a wrong index also shows in `wrIndex` in the cycle of the header write.
- An error in the full test or in the queue occupancy count shows as `overflow` disagreeing with the drop rule one cycle after the offending sample. It also shows as surplus or missing samples at the next header.

// File: rtl/rxring_pkg.sv
`timescale 1ns/1ps
package rxring_pkg;
  localparam int SAMPLE_W      = 32;
  localparam int HDR_VALID_BIT = 31;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic push;      // enqueue the incoming sample word
    logic pop;       // send the oldest queued sample to memory
    logic writeHdr;  // send the pending header to memory
  } ringStrobe_t;
endpackage

// File: rtl/rxring_ctrl.sv
`timescale 1ns/1ps
module rxring_ctrl
  import rxring_pkg::*;
#(
  parameter int NUM_DESC         = 4,
  parameter int SAMPLES_PER_DESC = 28,
  parameter int HDR_WORDS        = 4,
  parameter int QUEUE_DEPTH      = 2,
  parameter int SEQ_W            = 16,
  localparam int IDX_W  = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int OFF_W  = $clog2(HDR_WORDS + SAMPLES_PER_DESC),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [IDX_W-1:0]    rdIndex,
  input  logic                headLast,
  input  logic [IDX_W-1:0]    headIdx,
  output ringStrobe_t         strobe,
  output logic [ADDR_W-1:0]   pushAddr,
  output logic                pushLast,
  output logic [ADDR_W-1:0]   hdrAddr,
  output logic [SAMPLE_W-1:0] hdrWord,
  output logic [IDX_W-1:0]    wrIndex,
  output logic                overflow
);
  localparam int CNT_W  = (SAMPLES_PER_DESC > 1) ? $clog2(SAMPLES_PER_DESC) : 1;
  localparam int QCNT_W = $clog2(QUEUE_DEPTH + 1);
  localparam logic [CNT_W-1:0]  LAST_CNT = CNT_W'(SAMPLES_PER_DESC - 1);
  localparam logic [QCNT_W-1:0] Q_FULL   = QCNT_W'(QUEUE_DEPTH);

  function automatic logic [IDX_W-1:0] nextSlot(input logic [IDX_W-1:0] s);
    return (s == IDX_W'(NUM_DESC - 1)) ? '0 : IDX_W'(s + 1'b1);
  endfunction

  logic [CNT_W-1:0]  sampleCnt;
  logic [IDX_W-1:0]  fillIdx;
  logic [IDX_W-1:0]  hdrIdx;
  logic [IDX_W-1:0]  wrIdxQ;
  logic [QCNT_W-1:0] qCount;
  logic [SEQ_W-1:0]  seqNum;
  logic              hdrPending;
  logic              ovfQ;
  logic              ringFull;
  logic              queueFull;
  logic              accept;
  logic              popNow;

  // The full test is made only at a descriptor boundary, so a started descriptor always completes
  assign ringFull  = (sampleCnt == '0) && (nextSlot(fillIdx) == rdIndex);
  assign queueFull = (qCount == Q_FULL);
  assign accept    = sampleValid && !ringFull && !queueFull;
  assign popNow    = (qCount != '0) && !hdrPending;

  assign strobe.push     = accept;
  assign strobe.pop      = popNow;
  assign strobe.writeHdr = hdrPending;

  assign pushLast = (sampleCnt == LAST_CNT);
  assign pushAddr = {fillIdx, OFF_W'(HDR_WORDS + int'(sampleCnt))};
  assign hdrAddr  = {hdrIdx, OFF_W'(0)};

  always_comb begin
    hdrWord                = '0;
    hdrWord[HDR_VALID_BIT] = 1'b1;
    hdrWord[SEQ_W-1:0]     = seqNum;
  end

  // Fill position of the next accepted sample
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sampleCnt <= '0;
      fillIdx   <= '0;
    end else if (accept) begin
      if (pushLast) begin
        sampleCnt <= '0;
        fillIdx   <= nextSlot(fillIdx);
      end else begin
        sampleCnt <= sampleCnt + 1'b1;
      end
    end
  end

  // Queue occupancy
  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCount <= '0;
    end else begin
      case ({accept, popNow})
        2'b10:   qCount <= qCount + 1'b1;
        2'b01:   qCount <= qCount - 1'b1;
        default: qCount <= qCount;
      endcase
    end
  end

  // Header scheduling, sequence numbering and the published index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hdrPending <= 1'b0;
      hdrIdx     <= '0;
      seqNum     <= '0;
      wrIdxQ     <= '0;
    end else begin
      if (popNow && headLast) begin
        hdrPending <= 1'b1;
        hdrIdx     <= headIdx;
      end else if (hdrPending) begin
        hdrPending <= 1'b0;
      end
      if (hdrPending) begin
        seqNum <= seqNum + 1'b1;
        wrIdxQ <= nextSlot(hdrIdx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)            ovfQ <= 1'b0;
    else if (sampleValid) ovfQ <= !accept;
  end

  assign wrIndex  = wrIdxQ;
  assign overflow = ovfQ;
endmodule

// File: rtl/rxring_dp.sv
`timescale 1ns/1ps
module rxring_dp
  import rxring_pkg::*;
#(
  parameter int NUM_DESC         = 4,
  parameter int SAMPLES_PER_DESC = 28,
  parameter int HDR_WORDS        = 4,
  parameter int QUEUE_DEPTH      = 2,
  localparam int IDX_W  = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int OFF_W  = $clog2(HDR_WORDS + SAMPLES_PER_DESC),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  ringStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [ADDR_W-1:0]   pushAddr,
  input  logic                pushLast,
  input  logic [ADDR_W-1:0]   hdrAddr,
  input  logic [SAMPLE_W-1:0] hdrWord,
  output logic                headLast,
  output logic [IDX_W-1:0]    headIdx,
  output logic                memWrEn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [SAMPLE_W-1:0] memWrData
);
  localparam int PTR_W = (QUEUE_DEPTH > 1) ? $clog2(QUEUE_DEPTH) : 1;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : PTR_W'(p + 1'b1);
  endfunction

  logic [SAMPLE_W-1:0] qData [QUEUE_DEPTH];
  logic [ADDR_W-1:0]   qAddr [QUEUE_DEPTH];
  logic                qLast [QUEUE_DEPTH];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;

  always_ff @(posedge clk) begin
    for (int e = 0; e < QUEUE_DEPTH; e++) begin
      if (strobe.push && (wrPtr == PTR_W'(e))) begin
        qData[e] <= sampleData;
        qAddr[e] <= pushAddr;
        qLast[e] <= pushLast;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= nextPtr(wrPtr);
      if (strobe.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  assign headLast = qLast[rdPtr];
  assign headIdx  = qAddr[rdPtr][ADDR_W-1:OFF_W];

  // Registered memory port; the header has priority over queued samples
  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWrEn   <= 1'b0;
      memAddr   <= '0;
      memWrData <= '0;
    end else begin
      memWrEn <= strobe.writeHdr | strobe.pop;
      if (strobe.writeHdr) begin
        memAddr   <= hdrAddr;
        memWrData <= hdrWord;
      end else if (strobe.pop) begin
        memAddr   <= qAddr[rdPtr];
        memWrData <= qData[rdPtr];
      end
    end
  end
endmodule

// File: rtl/rx_desc_ring_writer.sv
`timescale 1ns/1ps
module rx_desc_ring_writer
  import rxring_pkg::*;
#(
  parameter int NUM_DESC         = 4,
  parameter int SAMPLES_PER_DESC = 28,
  parameter int HDR_WORDS        = 4,
  parameter int QUEUE_DEPTH      = 2,
  parameter int SEQ_W            = 16,
  localparam int IDX_W  = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int OFF_W  = $clog2(HDR_WORDS + SAMPLES_PER_DESC),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [31:0]       sampleData,
  input  logic [IDX_W-1:0]  rdIndex,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memWrData,
  output logic [IDX_W-1:0]  wrIndex,
  output logic              overflow
);
  ringStrobe_t         strobe;
  logic [ADDR_W-1:0]   pushAddr;
  logic                pushLast;
  logic [ADDR_W-1:0]   hdrAddr;
  logic [SAMPLE_W-1:0] hdrWord;
  logic                headLast;
  logic [IDX_W-1:0]    headIdx;

  rxring_ctrl #(
    .NUM_DESC(NUM_DESC), .SAMPLES_PER_DESC(SAMPLES_PER_DESC),
    .HDR_WORDS(HDR_WORDS), .QUEUE_DEPTH(QUEUE_DEPTH), .SEQ_W(SEQ_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .rdIndex(rdIndex),
    .headLast(headLast), .headIdx(headIdx), .strobe(strobe),
    .pushAddr(pushAddr), .pushLast(pushLast), .hdrAddr(hdrAddr), .hdrWord(hdrWord),
    .wrIndex(wrIndex), .overflow(overflow)
  );

  rxring_dp #(
    .NUM_DESC(NUM_DESC), .SAMPLES_PER_DESC(SAMPLES_PER_DESC),
    .HDR_WORDS(HDR_WORDS), .QUEUE_DEPTH(QUEUE_DEPTH)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .pushAddr(pushAddr), .pushLast(pushLast), .hdrAddr(hdrAddr), .hdrWord(hdrWord),
    .headLast(headLast), .headIdx(headIdx),
    .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData)
  );
endmodule

// File: rtl/rx_desc_ring_writer_chk.sv
`timescale 1ns/1ps
module rx_desc_ring_writer_chk #(
  parameter int NUM_DESC         = 4,
  parameter int SAMPLES_PER_DESC = 28,
  parameter int HDR_WORDS        = 4,
  parameter int QUEUE_DEPTH      = 2,
  parameter int SEQ_W            = 16,
  localparam int IDX_W  = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
  localparam int OFF_W  = $clog2(HDR_WORDS + SAMPLES_PER_DESC),
  localparam int ADDR_W = IDX_W + OFF_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleValid,
  input logic [31:0]       sampleData,
  input logic [IDX_W-1:0]  rdIndex,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memWrData,
  input logic [IDX_W-1:0]  wrIndex,
  input logic              overflow
);
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] slot;
  logic             isHdr;
  logic             isSample;
  assign off      = memAddr[OFF_W-1:0];
  assign slot     = memAddr[ADDR_W-1:OFF_W];
  assign isHdr    = memWrEn && (off == '0);
  assign isSample = memWrEn && (int'(off) >= HDR_WORDS);

  p_hdr_format_r3: assert property (@(posedge clk) disable iff (!rstN)
    isHdr |-> (memWrData[31] && (memWrData[30:16] == '0)));

  p_no_reserved_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (isHdr || isSample));

  p_idx_with_hdr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrIndex != $past(wrIndex)) |-> isHdr);

  p_idx_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    isHdr |-> (($past(wrIndex) == slot) &&
               (wrIndex == ((slot == IDX_W'(NUM_DESC - 1)) ? '0 : IDX_W'(slot + 1'b1)))));

  p_sample_slot_r5: assert property (@(posedge clk) disable iff (!rstN)
    isSample |-> (slot == wrIndex));

  p_ovf_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(sampleValid));

  p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(sampleValid) |-> $stable(overflow));
endmodule

bind rx_desc_ring_writer rx_desc_ring_writer_chk #(
  .NUM_DESC(NUM_DESC), .SAMPLES_PER_DESC(SAMPLES_PER_DESC),
  .HDR_WORDS(HDR_WORDS), .QUEUE_DEPTH(QUEUE_DEPTH), .SEQ_W(SEQ_W)
) u_chk (.*);

// File: tb/rx_desc_ring_writer_tb.sv
`timescale 1ns/1ps
module rx_desc_ring_writer_tb;
  localparam int NDESC  = 4;
  localparam int SPD    = 28;
  localparam int HDRW   = 4;
  localparam int IDX_W  = 2;
  localparam int OFF_W  = 5;
  localparam int ADDR_W = IDX_W + OFF_W;

  logic              clk = 1'b0;
  logic              rstN;
  logic              sampleValid;
  logic [31:0]       sampleData;
  logic [IDX_W-1:0]  rdIndex;
  logic              memWrEn;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0]       memWrData;
  logic [IDX_W-1:0]  wrIndex;
  logic              overflow;

  always #4 clk = ~clk;

  rx_desc_ring_writer u_dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .rdIndex(rdIndex), .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .wrIndex(wrIndex), .overflow(overflow)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];
  logic [31:0] shadow [NDESC][SPD];
  int wcnt [NDESC];
  int bFill = 0, bCnt = 0, expSlot = 0, expSeq = 0;
  bit prevValid = 1'b0, prevDropped = 1'b0;
  int consumeMode = 0;

  function automatic int nextSlot(input int s);
    return (s == NDESC - 1) ? 0 : s + 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus; the model applies the drop rule of R6 and the forced drop of R8
  task automatic step(input bit v, input logic [31:0] d, input bit forceDrop, input string tag);
    bit blocked, acc;
    @(negedge clk);
    if (prevValid) check(overflow === prevDropped, tag, "overflow after sample", overflow, prevDropped);
    if (consumeMode == 1 && ($urandom % 2 == 1) && rdIndex != wrIndex) rdIndex = rdIndex + 1'b1;
    if (consumeMode == 2 && rdIndex != wrIndex) rdIndex = rdIndex + 1'b1;
    sampleValid = v;
    sampleData  = d;
    if (v) begin
      blocked = (bCnt == 0) && (nextSlot(bFill) == int'(rdIndex));
      acc = !blocked && !forceDrop;
      if (acc) begin
        expQ.push_back(d);
        if (bCnt == SPD - 1) begin bCnt = 0; bFill = nextSlot(bFill); end
        else bCnt++;
      end
      prevDropped = !acc;
    end
    prevValid = v;
  endtask

  task automatic gapped(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, $urandom, 1'b0, tag);
      step(1'b0, 32'h0, 1'b0, tag);
    end
  endtask

  task automatic drain();
    int saved;
    saved = consumeMode;
    consumeMode = 2;
    repeat (16) step(1'b0, 32'h0, 1'b0, "R6");
    consumeMode = saved;
  endtask

  // Monitor of the memory port
  always @(negedge clk) begin
    int slot, off, bad;
    logic [31:0] e, firstAct, firstExp;
    if (rstN && memWrEn) begin
      slot = int'(memAddr[ADDR_W-1:OFF_W]);
      off  = int'(memAddr[OFF_W-1:0]);
      if (off >= HDRW) begin
        if (off - HDRW < SPD) shadow[slot][off-HDRW] = memWrData;
        wcnt[slot]++;
        check(slot == int'(wrIndex), "R5", "sample slot vs wrIndex", slot, wrIndex);
      end else if (off != 0) begin
        check(1'b0, "R3", "reserved header word written", off, 0);
      end else begin
        check(slot == expSlot, "R5", "header slot", slot, expSlot);
        check(wcnt[slot] == SPD, "R2", "sample writes before header", wcnt[slot], SPD);
        wcnt[slot] = 0;
        check(memWrData == {1'b1, 15'b0, 16'(expSeq)}, "R3", "header word",
              memWrData, {1'b1, 15'b0, 16'(expSeq)});
        check(int'(wrIndex) == nextSlot(slot), "R4", "wrIndex with header", wrIndex, nextSlot(slot));
        bad = 0;
        firstAct = '0;
        firstExp = '0;
        for (int k = 0; k < SPD; k++) begin
          if (expQ.size() == 0) begin
            bad++;
          end else begin
            e = expQ.pop_front();
            if (shadow[slot][k] !== e) begin
              if (bad == 0) begin firstAct = shadow[slot][k]; firstExp = e; end
              bad++;
            end
          end
        end
        check(bad == 0, "R1", "descriptor sample content", firstAct, firstExp);
        expSeq  = (expSeq + 1) % 65536;
        expSlot = nextSlot(expSlot);
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not end)");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int startRd;
    void'($urandom(32'd20240611));
    for (int s = 0; s < NDESC; s++) wcnt[s] = 0;
    rstN = 1'b0; sampleValid = 1'b0; sampleData = '0; rdIndex = '0;
    repeat (3) @(negedge clk);
    check(memWrEn === 1'b0, "R9", "memWrEn in reset", memWrEn, 0);
    check(overflow === 1'b0, "R9", "overflow in reset", overflow, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(wrIndex === '0, "R4", "wrIndex after reset", wrIndex, 0);
    check(memWrEn === 1'b0, "R9", "memWrEn after reset", memWrEn, 0);

    // Random gapped traffic with a randomly lagging consumer
    consumeMode = 1;
    for (int i = 0; i < 1500; i++)
      step(!prevValid && ($urandom % 10 < 6), $urandom, 1'b0, "R6");
    while (bCnt != 0) gapped(1, "R1");
    drain();
    check(int'(wrIndex) == bFill, "R4", "wrIndex after random phase", wrIndex, bFill);

    // R6: consumer stalled, ring fills to NDESC-1 descriptors then drops
    consumeMode = 0;
    startRd = int'(rdIndex);
    gapped(NDESC * SPD, "R6");
    repeat (6) step(1'b0, 32'h0, 1'b0, "R6");
    check(int'(wrIndex) == (startRd + NDESC - 1) % NDESC, "R6", "wrIndex when full",
          wrIndex, (startRd + NDESC - 1) % NDESC);
    check(overflow === 1'b1, "R6", "overflow held while full", overflow, 1);

    // R7: one slot freed, writing restarts at the blocked slot
    rdIndex = rdIndex + 1'b1;
    step(1'b1, 32'hABCD_1234, 1'b0, "R7");
    step(1'b0, 32'h0, 1'b0, "R7");
    gapped(SPD - 1, "R7");
    repeat (6) step(1'b0, 32'h0, 1'b0, "R7");
    check(int'(wrIndex) == startRd, "R7", "wrIndex after resume", wrIndex, startRd);
    drain();

    // R8: back-to-back stream from a descriptor boundary; third sample after the 28th is dropped
    consumeMode = 0;
    for (int i = 0; i < 40; i++) step(1'b1, $urandom, (i == SPD + 2), "R8");
    step(1'b0, 32'h0, 1'b0, "R8");
    gapped(SPD - 11, "R8");
    drain();
    check(expQ.size() == 0, "R2", "samples left unwritten", expQ.size(), 0);
    check(int'(wrIndex) == bFill, "R4", "final wrIndex", wrIndex, bFill);
    check(overflow === 1'b0, "R6", "overflow after recovery", overflow, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule